// File: doc/BRIEF.md
# Shared-Timebase Compare/Capture Array

This block pairs one 16-bit time-base counter with five compare/capture channels. Every channel reads the same counter value. Each channel is set on its own to one of these jobs: record the counter when its input pin shows an edge, raise a flag when the counter wraps, flip its output pin when the counter reaches a programmed value, or produce an 8-bit pulse-width-modulated waveform. Software reaches all state through a byte-wide address/data bus. It collects events through per-channel flags, which combine into one interrupt line.

The counter advances only when two conditions hold together: the software run bit is set, and the `cnt_en` input is high. `cnt_en` is the hook for any external prescaler. Channel input pins may be asynchronous to the clock; each passes through a synchronizer before edge detection.

Register map (byte addresses):

| Address | Contents |
|---|---|
| 0 | Control register. Bit 0 is the run bit. |
| 1, 2 | Counter low and high bytes. Readable and writable. |
| 3 | Flags. Bit i belongs to channel i. Writing 1 to a bit clears it. |
| 4 | Interrupt enables. Bit i belongs to channel i. |
| 8 + 4·i | Channel i control. Bits [2:0] hold the mode; bit 3 is the toggle/level bit. |
| 9 + 4·i | Channel i data, low byte. |
| 10 + 4·i | Channel i data, high byte. |

Mode codes:

| Code | Mode |
|---|---|
| 000 | Off |
| 001 | Capture on rising edge |
| 010 | Capture on falling edge |
| 011 | Capture on either edge |
| 100 | Rollover timer |
| 101 | Toggle on compare |
| 110 | PWM |
| 111 | Reserved |

Top module: `ccu_array`

## Requirements
- R1: While the run bit (address 0, bit 0) is 1, the counter increases by one on each clock in which `cnt_en` is high, and it wraps from FFFF to 0000.
- R2: While the run bit is 0, the counter holds its value whatever `cnt_en` does. A write to address 1 or 2 replaces the counter's low or high byte.
- R3: In mode 001, a 0-to-1 change on the channel pin copies the counter into the channel data register and sets the channel flag. A 1-to-0 change does neither.
- R4: In mode 010, a 1-to-0 change on the pin captures the counter and sets the flag. A 0-to-1 change does neither.
- R5: In mode 011, a change on the pin in either direction captures the counter and sets the flag.
- R6: In mode 100, the channel flag is set on the counter step that wraps the counter from FFFF to 0000.
- R7: In mode 101, on a counter step taken while the counter equals the channel data, the channel output inverts and the flag is set. Control bit 3 reads back the output level. Writing control bit 3 sets that level.
- R8: In mode 110, the channel output is 0 while the counter low byte is below the data low byte, and 1 when it is equal or above. On each low-byte wrap from FF to 00, the data high byte is copied into the data low byte.
- R9: Writing to address 3 clears exactly the flags whose written bit is 1 and leaves the other flags unchanged.
- R10: `irq` is high exactly one clock after any channel has both its flag (address 3) and its enable (address 4, same bit position) set.
- R11: After reset, the counter, run bit, flags, enables, channel modes and data are zero, and `irq` and all `cc_out` bits are 0.
- R12: In mode 000 and mode 111, pin edges neither capture nor set the flag, and the channel output stays 0.
- R13: `rd_data` shows the register at `addr` one clock after `addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-enable tick for the time base |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 5 | Register byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| cc_in | input | 5 | Channel input pins, may be asynchronous |
| cc_out | output | 5 | Registered channel output pins |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `cnt_en`, `wr_en`, `addr` and `wr_data` are synchronous to `clk` and stable around the rising edge. The counter checks also assume that a counter byte write is the only event that may break a step or a hold. The bench drives every bus input and `cnt_en` on the falling edge. It holds each pin level for at least five clocks, so the synchronizer and edge detector see one clean transition. During capture tests the counter is stopped, so the captured value does not depend on the synchronizer delay.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  typedef enum logic [2:0] {
    M_OFF      = 3'b000,
    M_CAP_RISE = 3'b001,
    M_CAP_FALL = 3'b010,
    M_CAP_BOTH = 3'b011,
    M_TIMER    = 3'b100,
    M_CMP      = 3'b101,
    M_PWM      = 3'b110,
    M_RSVD     = 3'b111
  } ccu_mode_e;

  // global register addresses
  localparam int A_CTRL   = 0;
  localparam int A_CNT_LO = 1;
  localparam int A_CNT_HI = 2;
  localparam int A_FLAG   = 3;
  localparam int A_IEN    = 4;

  // channel register window
  localparam int A_CH_BASE   = 8;
  localparam int A_CH_STRIDE = 4;
  localparam int O_CTRL      = 0;
  localparam int O_DLO       = 1;
  localparam int O_DHI       = 2;

  // bit position of the toggle/level bit in a channel control byte
  localparam int TOG_BIT = 3;
endpackage

// File: rtl/ccu_sync.sv
module ccu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/ccu_timebase.sv
module ccu_timebase #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          cnt_en,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic          step,
  output logic          roll,
  output logic          lo_roll
);
  assign step    = run & cnt_en;
  assign roll    = step & (&cnt);
  assign lo_roll = step & (&cnt[BW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      if (step)  cnt <= cnt + 1'b1;
      // a byte write overrides the step for that byte
      if (wr_lo) cnt[BW-1:0]  <= wdata;
      if (wr_hi) cnt[CW-1:BW] <= wdata;
    end
  end
endmodule

// File: rtl/ccu_channel.sv
module ccu_channel
  import ccu_pkg::*;
#(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          roll,
  input  logic          lo_roll,
  input  logic [CW-1:0] cnt,
  input  logic          pin,
  input  logic          ctrl_we,
  input  logic          dlo_we,
  input  logic          dhi_we,
  input  logic [BW-1:0] wdata,
  output logic [2:0]    mode,
  output logic          tog,
  output logic [CW-1:0] data,
  output logic          hit,
  output logic          pin_out
);
  ccu_mode_e mode_q;
  logic      prev_q;
  logic      rise, fall, cap, match, tog_n;

  assign rise = pin & ~prev_q;
  assign fall = ~pin & prev_q;

  always_comb begin
    unique case (mode_q)
      M_CAP_RISE: cap = rise;
      M_CAP_FALL: cap = fall;
      M_CAP_BOTH: cap = rise | fall;
      default:    cap = 1'b0;
    endcase
  end

  assign match = (mode_q == M_CMP) && step && (cnt == data);
  assign tog_n = ctrl_we ? wdata[TOG_BIT] : (match ? ~tog : tog);
  assign hit   = cap | ((mode_q == M_TIMER) & roll) | match;
  assign mode  = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_OFF;
      prev_q  <= 1'b0;
      tog     <= 1'b0;
      data    <= '0;
      pin_out <= 1'b0;
    end else begin
      prev_q <= pin;
      tog    <= tog_n;
      if (ctrl_we) mode_q <= ccu_mode_e'(wdata[2:0]);

      // hardware updates take precedence over bus writes
      if (cap) begin
        data <= cnt;
      end else begin
        if (mode_q == M_PWM && lo_roll) data[BW-1:0] <= data[CW-1:BW];
        else if (dlo_we)                data[BW-1:0] <= wdata;
        if (dhi_we)                     data[CW-1:BW] <= wdata;
      end

      unique case (mode_q)
        M_CMP:   pin_out <= tog_n;
        M_PWM:   pin_out <= (cnt[BW-1:0] >= data[BW-1:0]);
        default: pin_out <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ccu_array.sv
module ccu_array
  import ccu_pkg::*;
#(
  parameter int NCH         = 5,
  parameter int BW          = 8,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2,
  localparam int CW = 2 * BW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BW-1:0]     wr_data,
  output logic [BW-1:0]     rd_data,
  input  logic [NCH-1:0]    cc_in,
  output logic [NCH-1:0]    cc_out,
  output logic              irq
);
  logic           run_q;
  logic [NCH-1:0] flag_q, ien_q;
  logic [CW-1:0]  cnt;
  logic           step, roll, lo_roll;
  logic [BW-1:0]  rd_n;

  logic wr_ctrl, wr_lo, wr_hi, wr_flag, wr_ien;
  assign wr_ctrl = wr_en && addr == ADDR_W'(A_CTRL);
  assign wr_lo   = wr_en && addr == ADDR_W'(A_CNT_LO);
  assign wr_hi   = wr_en && addr == ADDR_W'(A_CNT_HI);
  assign wr_flag = wr_en && addr == ADDR_W'(A_FLAG);
  assign wr_ien  = wr_en && addr == ADDR_W'(A_IEN);

  ccu_timebase #(.BW(BW)) i_tb (
    .clk(clk), .rst(rst), .run(run_q), .cnt_en(cnt_en),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wr_data),
    .cnt(cnt), .step(step), .roll(roll), .lo_roll(lo_roll)
  );

  logic [2:0]     ch_mode [NCH];
  logic [CW-1:0]  ch_data [NCH];
  logic [NCH-1:0] ch_tog, ch_hit, ch_pin;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int BASE = A_CH_BASE + i * A_CH_STRIDE;

    ccu_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst(rst), .d(cc_in[i]), .q(ch_pin[i])
    );

    ccu_channel #(.BW(BW)) i_chan (
      .clk(clk), .rst(rst), .step(step), .roll(roll), .lo_roll(lo_roll),
      .cnt(cnt), .pin(ch_pin[i]),
      .ctrl_we(wr_en && addr == ADDR_W'(BASE + O_CTRL)),
      .dlo_we (wr_en && addr == ADDR_W'(BASE + O_DLO)),
      .dhi_we (wr_en && addr == ADDR_W'(BASE + O_DHI)),
      .wdata(wr_data),
      .mode(ch_mode[i]), .tog(ch_tog[i]), .data(ch_data[i]),
      .hit(ch_hit[i]), .pin_out(cc_out[i])
    );
  end

  // read mux: global registers first, then the channel windows
  always_comb begin
    rd_n = '0;
    case (addr)
      ADDR_W'(A_CTRL):   rd_n[0]       = run_q;
      ADDR_W'(A_CNT_LO): rd_n          = cnt[BW-1:0];
      ADDR_W'(A_CNT_HI): rd_n          = cnt[CW-1:BW];
      ADDR_W'(A_FLAG):   rd_n[NCH-1:0] = flag_q;
      ADDR_W'(A_IEN):    rd_n[NCH-1:0] = ien_q;
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(A_CH_BASE + i * A_CH_STRIDE + O_CTRL)) begin
        rd_n[2:0]     = ch_mode[i];
        rd_n[TOG_BIT] = ch_tog[i];
      end
      if (addr == ADDR_W'(A_CH_BASE + i * A_CH_STRIDE + O_DLO)) rd_n = ch_data[i][BW-1:0];
      if (addr == ADDR_W'(A_CH_BASE + i * A_CH_STRIDE + O_DHI)) rd_n = ch_data[i][CW-1:BW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      flag_q  <= '0;
      ien_q   <= '0;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_ctrl) run_q <= wr_data[0];
      if (wr_ien)  ien_q <= wr_data[NCH-1:0];
      // a flag being set in the same clock as its clear stays set
      flag_q  <= ch_hit | (flag_q & ~(wr_flag ? wr_data[NCH-1:0] : '0));
      irq     <= |(flag_q & ien_q);
      rd_data <= rd_n;
    end
  end
endmodule

// File: rtl/ccu_array_chk.sv
module ccu_array_chk
  import ccu_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int BW     = 8,
  parameter int ADDR_W = 5,
  localparam int CW = 2 * BW
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              cnt_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CW-1:0]     cnt,
  input logic [NCH-1:0]    flags,
  input logic [NCH-1:0]    ien,
  input logic              irq,
  input logic [NCH-1:0]    cc_out
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (addr == ADDR_W'(A_CNT_LO) || addr == ADDR_W'(A_CNT_HI));

  // R1: a permitted step moves the counter up by exactly one, wrapping
  a_r1_count: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_en && !cnt_wr) |=> cnt == CW'($past(cnt) + 1'b1));

  // R2: a stopped counter holds unless software writes it
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt));

  // R10: no enabled flag means no interrupt on the following clock
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((flags & ien) == '0) |=> !irq);

  // R11: the clock after a reset clock leaves flags and outputs cleared
  a_r11_reset: assert property (@(posedge clk)
    $past(rst) |-> (flags == '0 && !irq && cc_out == '0));
endmodule

bind ccu_array ccu_array_chk #(.NCH(NCH), .BW(BW), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .run(run_q), .cnt_en(cnt_en), .wr_en(wr_en),
  .addr(addr), .cnt(cnt), .flags(flag_q), .ien(ien_q), .irq(irq),
  .cc_out(cc_out)
);

// File: tb/test_ccu_array.sv
module test_ccu_array;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [NCH-1:0] cc_in = '0;
  logic [NCH-1:0] cc_out;
  logic       irq;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccu_array i_ccu_array (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cc_in(cc_in), .cc_out(cc_out),
    .irq(irq)
  );

  // capture vectors: {mode[2:0], start level, end level, counter[15:0],
  //                   expected flag, expected data[15:0]}
  localparam logic [37:0] VEC [8] = '{
    {3'b001, 1'b0, 1'b1, 16'h1234, 1'b1, 16'h1234},
    {3'b001, 1'b1, 1'b0, 16'h2345, 1'b0, 16'hA5A5},
    {3'b010, 1'b1, 1'b0, 16'h3456, 1'b1, 16'h3456},
    {3'b010, 1'b0, 1'b1, 16'h4567, 1'b0, 16'hA5A5},
    {3'b011, 1'b0, 1'b1, 16'h5678, 1'b1, 16'h5678},
    {3'b011, 1'b1, 1'b0, 16'h6789, 1'b1, 16'h6789},
    {3'b000, 1'b0, 1'b1, 16'h789A, 1'b0, 16'hA5A5},
    {3'b111, 1'b1, 1'b0, 16'h89AB, 1'b0, 16'hA5A5}
  };

  function automatic string tag_of(logic [2:0] m);
    case (m)
      3'b001:  return "R3";
      3'b010:  return "R4";
      3'b011:  return "R5";
      default: return "R12";
    endcase
  endfunction

  function automatic int cha(int ch, int off);
    return 8 + 4 * ch + off;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = 5'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk);
    addr = 5'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic rd16(int a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 1, hi);
    d = {hi, lo};
  endtask

  task automatic set_cnt(logic [15:0] v);
    wr(1, v[7:0]);
    wr(2, v[15:8]);
  endtask

  task automatic pulse(int k);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (k) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;

    idle(3);
    rst = 1'b0;
    idle(1);

    // R11: reset state
    check("R11 irq", irq, 0);
    check("R11 cc_out", cc_out, 0);
    rd(0, b);    check("R11 run bit", b, 0);
    rd16(1, w);  check("R11 counter", w, 0);
    rd(3, b);    check("R11 flags", b, 0);
    rd16(cha(0, 1), w); check("R11 ch0 data", w, 0);

    // capture and mode-ignore vectors on channel 0, counter stopped
    for (int v = 0; v < 8; v++) begin
      logic [2:0]  m;
      logic [15:0] c, ed;
      logic        s, e, ef;
      {m, s, e, c, ef, ed} = VEC[v];
      cc_in[0] = s;
      idle(5);
      wr(cha(0, 0), {5'b0, m});
      set_cnt(c);
      wr(cha(0, 1), 8'hA5);
      wr(cha(0, 2), 8'hA5);
      wr(3, 8'h1F);
      cc_in[0] = e;
      idle(5);
      rd(3, b);          check({tag_of(m), " flag"}, b[0], ef);
      rd16(cha(0, 1), w); check({tag_of(m), " data"}, w, ed);
      check({tag_of(m), " output"}, cc_out[0], 0);
    end

    // R2: counter writes while stopped, and no counting while stopped
    set_cnt(16'hBEEF);
    rd16(1, w); check("R2 counter write", w, 16'hBEEF);
    pulse(5);
    rd16(1, w); check("R2 stopped counter holds", w, 16'hBEEF);

    // R1: counting while running
    set_cnt(16'h0010);
    wr(0, 8'h01);
    pulse(7);
    rd16(1, w); check("R1 count by cnt_en", w, 16'h0017);
    idle(4);
    rd16(1, w); check("R1 no count without cnt_en", w, 16'h0017);

    // R6 and R1 wrap: channel 1 timer mode
    wr(cha(1, 0), 8'h04);
    wr(3, 8'h1F);
    set_cnt(16'hFFFE);
    pulse(3);
    rd16(1, w); check("R1 wrap", w, 16'h0001);
    rd(3, b);   check("R6 timer flag", b, 8'h02);

    // R10 and R9: interrupt combine and write-one-to-clear
    check("R10 irq without enable", irq, 0);
    wr(4, 8'h02);
    idle(2);
    check("R10 irq with enable", irq, 1);
    rd(4, b);   check("R13 read of enables", b, 8'h02);
    wr(3, 8'h01);
    rd(3, b);   check("R9 unwritten flag kept", b, 8'h02);
    wr(3, 8'h02);
    rd(3, b);   check("R9 written flag cleared", b, 8'h00);
    idle(1);
    check("R10 irq after clear", irq, 0);

    // R7: compare with toggle on channel 2
    wr(cha(2, 1), 8'h05);
    wr(cha(2, 2), 8'h00);
    set_cnt(16'h0003);
    wr(cha(2, 0), 8'h05);
    idle(2);
    check("R7 output before match", cc_out[2], 0);
    pulse(4);
    check("R7 output toggled", cc_out[2], 1);
    rd(3, b);         check("R7 match flag", b, 8'h04);
    rd(cha(2, 0), b); check("R7 level bit readback", b, 8'h0D);
    wr(cha(2, 0), 8'h05);
    idle(2);
    check("R7 level bit write", cc_out[2], 0);

    // R8: PWM on channel 3
    wr(0, 8'h00);
    set_cnt(16'h0010);
    wr(cha(3, 1), 8'h40);
    wr(cha(3, 2), 8'h20);
    wr(cha(3, 0), 8'h06);
    idle(2);
    check("R8 low below duty", cc_out[3], 0);
    wr(1, 8'h50);
    idle(2);
    check("R8 high above duty", cc_out[3], 1);
    wr(1, 8'h40);
    idle(2);
    check("R8 high at equal", cc_out[3], 1);
    set_cnt(16'h00FE);
    wr(0, 8'h01);
    pulse(2);
    rd(cha(3, 1), b); check("R8 reload on low-byte wrap", b, 8'h20);
    check("R8 output after reload", cc_out[3], 0);

    finish_up();
  end
endmodule